// File: doc/BRIEF.md
# Software-Triggered Reset Sequencer

This block holds an 8-bit control register that software reads and writes through a simple port. When software sets the CPU-reset trigger bit from 0 to 1, the block runs a reset sequence. The sequence type comes from the register contents at the moment of that write.

A soft reset drives the processor INIT output low for a fixed number of bus-clock periods. Those periods are counted on a bus clock enable. A hard reset drives three outputs low together for a millisecond-scale window: platform reset, bus reset and suspend status. When the full-power-cycle bit is set, a hard reset also drives the three sleep-state outputs low for a second-scale window. With that bit set, the three external requests (reset button, power-good loss, watchdog expiry) each start the same power cycle on the sleep outputs alone.

The controller is a four-state machine. Its states are `ST_IDLE`, `ST_SOFT`, `ST_HARD` and `ST_POWER`. The transitions are:
- soft trigger: `ST_IDLE`→`ST_SOFT`
- hard trigger: `ST_IDLE`→`ST_HARD`
- external request with the full bit stored: `ST_IDLE`→`ST_POWER`
- soft done: `ST_SOFT`→`ST_IDLE`
- hard done without the full bit: `ST_HARD`→`ST_IDLE`
- hard done with the full bit: `ST_HARD`→`ST_POWER`
- power done: `ST_POWER`→`ST_IDLE`

A single cycle counter runs across `ST_HARD` and `ST_POWER`. This makes the sleep window measure from the start of the sequence.

Top module: `rsq_ctrl`

## Requirements
- R1: After reset the register reads 00h and every reset and sleep output is high (inactive).
- R2: A write stores data bits 3:1. A read returns them in the same positions, with bits 7:4 and bit 0 always reading 0. Bit 3 is the full-power-cycle bit, bit 2 is the trigger bit and bit 1 is the reset-type bit.
- R3: A sequence starts only on a write with bit 2 = 1 while the stored bit 2 is 0. A write of bit 2 = 1 when it is already stored as 1 starts nothing.
- R4: On a trigger written with bit 1 = 0, `init_n` goes low in the next cycle and stays low until exactly SOFT_TICKS cycles with `bus_ce` high have been counted. No other output moves.
- R5: On a trigger written with bit 1 = 1, `pltrst_n`, `pcirst_n` and `susstat_n` are low for exactly HARD_CYC cycles, starting the cycle after the write.
- R6: On a hard trigger written with bit 3 = 1, `slp3_n`, `slp4_n` and `slp5_n` are low for exactly FULL_CYC cycles (FULL_CYC > HARD_CYC) from the same start.
- R7: With the stored bit 3 = 0, the sleep outputs stay high through every sequence and every external request.
- R8: In idle with stored bit 3 = 1, a cycle with `sysrst_req`, `pwrgd_lost` or `wdog_req` high drives the sleep outputs low for FULL_CYC cycles. The platform, bus, suspend and INIT outputs stay high.
- R9: While any output is low, register writes and external requests are ignored. The register keeps its value and the running sequence is not extended.
- R10: When a hard or power-cycle sequence ends, the register returns to 00h. A soft sequence leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Platform clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | One-cycle enable marking each bus clock period |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sysrst_req | input | 1 | Reset button request, active high |
| pwrgd_lost | input | 1 | Power-good loss request, active high |
| wdog_req | input | 1 | Watchdog reset request, active high |
| init_n | output | 1 | Processor INIT, active low |
| pltrst_n | output | 1 | Platform reset, active low |
| pcirst_n | output | 1 | Bus reset, active low |
| susstat_n | output | 1 | Suspend status, active low |
| slp3_n | output | 1 | Sleep-state 3 output, active low |
| slp4_n | output | 1 | Sleep-state 4 output, active low |
| slp5_n | output | 1 | Sleep-state 5 output, active low |

## Verification
The hardest case to reach from the ports is a request arriving mid-sequence. Examples are a second trigger write or a watchdog pulse during a hard reset, or a rewrite during a soft pulse whose length depends on a sparse enable. The bench sweeps every value of the low nibble written into an idle register, with the `bus_ce` period varied from one to four cycles. It then repeats requests in the middle of running sequences and counts low cycles and counted enables on each output against the configured lengths.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SOFT  = 2'd1,
        ST_HARD  = 2'd2,
        ST_POWER = 2'd3
    } rsq_state_t;

    // positions inside the 8-bit register image
    localparam int FULL_POS = 3;
    localparam int TRIG_POS = 2;
    localparam int TYPE_POS = 1;
endpackage

// File: rtl/rsq_ctl_reg.sv
module rsq_ctl_reg
    import rsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ok,
    input  logic       clr,
    input  logic [7:0] wdata,
    output logic [2:0] ctl,
    output logic [7:0] rdata
);
    // ctl[2] = full cycle, ctl[1] = trigger, ctl[0] = reset type
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl <= 3'b000;
        else if (clr)
            ctl <= 3'b000;
        else if (wr_ok)
            ctl <= {wdata[FULL_POS], wdata[TRIG_POS], wdata[TYPE_POS]};
    end

    always_comb begin
        rdata = 8'h00;
        rdata[FULL_POS] = ctl[2];
        rdata[TRIG_POS] = ctl[1];
        rdata[TYPE_POS] = ctl[0];
    end
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int SOFT_TICKS = 16,
    parameter int HARD_CYC   = 40,
    parameter int FULL_CYC   = 120,
    parameter int CW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_ce,
    input  logic          trig_hit,
    input  logic          trig_hard,
    input  logic          ext_hit,
    input  logic          full_sel,
    input  logic [CW-1:0] cnt,
    output rsq_state_t    state,
    output logic          tmr_clr,
    output logic          tmr_inc,
    output logic          reg_clr,
    output logic          init_n,
    output logic          plat_n,
    output logic          slp_n
);
    localparam logic [CW-1:0] SOFT_LAST = CW'(SOFT_TICKS - 1);
    localparam logic [CW-1:0] HARD_LAST = CW'(HARD_CYC - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(FULL_CYC - 1);

    rsq_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (trig_hit)
                    state_nxt = trig_hard ? ST_HARD : ST_SOFT;
                else if (ext_hit)
                    state_nxt = ST_POWER;
            end
            ST_SOFT: begin
                if (bus_ce && cnt == SOFT_LAST)
                    state_nxt = ST_IDLE;
            end
            ST_HARD: begin
                if (cnt == HARD_LAST)
                    state_nxt = full_sel ? ST_POWER : ST_IDLE;
            end
            ST_POWER: begin
                if (cnt == FULL_LAST)
                    state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_clr = (state_nxt == ST_IDLE);
        tmr_inc = (state == ST_SOFT) ? bus_ce : (state != ST_IDLE);
        reg_clr = (state == ST_HARD || state == ST_POWER) && (state_nxt == ST_IDLE);
        init_n  = (state != ST_SOFT);
        plat_n  = (state != ST_HARD);
        slp_n   = !((state == ST_HARD && full_sel) || state == ST_POWER);
    end
endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int CLK_KHZ    = 100000,
    parameter int SOFT_TICKS = 16,
    parameter int HARD_CYC   = CLK_KHZ * 11 / 2,
    parameter int FULL_CYC   = CLK_KHZ * 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_ce,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sysrst_req,
    input  logic       pwrgd_lost,
    input  logic       wdog_req,
    output logic       init_n,
    output logic       pltrst_n,
    output logic       pcirst_n,
    output logic       susstat_n,
    output logic       slp3_n,
    output logic       slp4_n,
    output logic       slp5_n
);
    localparam int MAXC = (FULL_CYC > SOFT_TICKS) ? FULL_CYC : SOFT_TICKS;
    localparam int CW   = $clog2(MAXC + 1);

    rsq_state_t    state;
    logic [2:0]    ctl;
    logic [CW-1:0] cnt;
    logic          wr_ok, trig_hit, ext_hit;
    logic          tmr_clr, tmr_inc, reg_clr;
    logic          plat_n, slp_n;

    assign wr_ok    = reg_wr && (state == ST_IDLE);
    assign trig_hit = wr_ok && reg_wdata[TRIG_POS] && !ctl[1];
    assign ext_hit  = (state == ST_IDLE) && ctl[2] && (sysrst_req || pwrgd_lost || wdog_req);

    rsq_ctl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ok (wr_ok),
        .clr   (reg_clr),
        .wdata (reg_wdata),
        .ctl   (ctl),
        .rdata (reg_rdata)
    );

    rsq_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .cnt   (cnt)
    );

    rsq_fsm #(
        .SOFT_TICKS (SOFT_TICKS),
        .HARD_CYC   (HARD_CYC),
        .FULL_CYC   (FULL_CYC),
        .CW         (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_ce    (bus_ce),
        .trig_hit  (trig_hit),
        .trig_hard (reg_wdata[TYPE_POS]),
        .ext_hit   (ext_hit),
        .full_sel  (ctl[2]),
        .cnt       (cnt),
        .state     (state),
        .tmr_clr   (tmr_clr),
        .tmr_inc   (tmr_inc),
        .reg_clr   (reg_clr),
        .init_n    (init_n),
        .plat_n    (plat_n),
        .slp_n     (slp_n)
    );

    assign pltrst_n  = plat_n;
    assign pcirst_n  = plat_n;
    assign susstat_n = plat_n;
    assign slp3_n    = slp_n;
    assign slp4_n    = slp_n;
    assign slp5_n    = slp_n;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_ce,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       init_n,
    input logic       pltrst_n,
    input logic       pcirst_n,
    input logic       susstat_n,
    input logic       slp3_n,
    input logic       slp4_n,
    input logic       slp5_n
);
    logic all_hi;
    assign all_hi = init_n && pltrst_n && slp3_n;

    // R2
    resv_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:4] == 4'h0 && reg_rdata[0] == 1'b0);

    // R3
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[2] && !reg_rdata[2] && all_hi) |=> (!init_n || !pltrst_n));

    // R4
    soft_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_n) |-> $past(bus_ce));

    // R4
    soft_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> (pltrst_n && slp3_n));

    // R5
    plat_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pltrst_n == pcirst_n) && (pcirst_n == susstat_n));

    // R6
    slp_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slp3_n == slp4_n) && (slp4_n == slp5_n));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_n && reg_wr) |=> $stable(reg_rdata));

    // R10
    hard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pltrst_n) && slp3_n) |-> (reg_rdata == 8'h00));
endmodule

bind rsq_ctrl rsq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ce    (bus_ce),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .init_n    (init_n),
    .pltrst_n  (pltrst_n),
    .pcirst_n  (pcirst_n),
    .susstat_n (susstat_n),
    .slp3_n    (slp3_n),
    .slp4_n    (slp4_n),
    .slp5_n    (slp5_n)
);

// File: tb/rsq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rsq_ctrl_tb_top;
    localparam int SOFT = 16;
    localparam int HARD = 40;
    localparam int FULL = 120;
    localparam int SETTLE = FULL + 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_ce = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sysrst_req = 1'b0, pwrgd_lost = 1'b0, wdog_req = 1'b0;
    logic       init_n, pltrst_n, pcirst_n, susstat_n, slp3_n, slp4_n, slp5_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ce_per = 1;
    int lo_init = 0, ce_init = 0, lo_plt = 0, lo_pci = 0, lo_sus = 0;
    int lo_s3 = 0, lo_s4 = 0, lo_s5 = 0;
    int b_init, b_ce, b_plt, b_pci, b_sus, b_s3, b_s4, b_s5;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsq_ctrl #(
        .CLK_KHZ    (1000),
        .SOFT_TICKS (SOFT),
        .HARD_CYC   (HARD),
        .FULL_CYC   (FULL)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_ce     (bus_ce),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .sysrst_req (sysrst_req),
        .pwrgd_lost (pwrgd_lost),
        .wdog_req   (wdog_req),
        .init_n     (init_n),
        .pltrst_n   (pltrst_n),
        .pcirst_n   (pcirst_n),
        .susstat_n  (susstat_n),
        .slp3_n     (slp3_n),
        .slp4_n     (slp4_n),
        .slp5_n     (slp5_n)
    );

    // monitor: samples outputs and drives the bus enable, all at the falling edge
    always @(negedge clk) begin
        logic nce;
        cyc++;
        nce = ((cyc % ce_per) == 0);
        if (!init_n) lo_init++;
        if (!init_n && nce) ce_init++;
        if (!pltrst_n) lo_plt++;
        if (!pcirst_n) lo_pci++;
        if (!susstat_n) lo_sus++;
        if (!slp3_n) lo_s3++;
        if (!slp4_n) lo_s4++;
        if (!slp5_n) lo_s5++;
        bus_ce = nce;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mark();
        b_init = lo_init; b_ce = ce_init; b_plt = lo_plt; b_pci = lo_pci;
        b_sus = lo_sus; b_s3 = lo_s3; b_s4 = lo_s4; b_s5 = lo_s5;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic ext_pulse(input int src);
        @(negedge clk);
        case (src)
            0: sysrst_req = 1'b1;
            1: pwrgd_lost = 1'b1;
            default: wdog_req = 1'b1;
        endcase
        @(negedge clk);
        sysrst_req = 1'b0;
        pwrgd_lost = 1'b0;
        wdog_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // checks the low-cycle counts accumulated since mark()
    task automatic expect_lows(input string req, input int e_ce, input int e_plt, input int e_slp);
        chk(ce_init - b_ce == e_ce, {req, " init enables"}, ce_init - b_ce, e_ce);
        if (e_ce == 0) chk(lo_init - b_init == 0, {req, " init low"}, lo_init - b_init, 0);
        chk(lo_plt - b_plt == e_plt, {req, " pltrst low"}, lo_plt - b_plt, e_plt);
        chk(lo_pci - b_pci == e_plt, {req, " pcirst low"}, lo_pci - b_pci, e_plt);
        chk(lo_sus - b_sus == e_plt, {req, " susstat low"}, lo_sus - b_sus, e_plt);
        chk(lo_s3 - b_s3 == e_slp, {req, " slp3 low"}, lo_s3 - b_s3, e_slp);
        chk(lo_s4 - b_s4 == e_slp, {req, " slp4 low"}, lo_s4 - b_s4, e_slp);
        chk(lo_s5 - b_s5 == e_slp, {req, " slp5 low"}, lo_s5 - b_s5, e_slp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk(reg_rdata == 8'h00, "R1 register", reg_rdata, 0);
        chk(init_n && pltrst_n && pcirst_n && susstat_n, "R1 reset outputs", 0, 1);
        chk(slp3_n && slp4_n && slp5_n, "R1 sleep outputs", 0, 1);

        // R2 R3 R4 R5 R6 R7 R10: sweep all low-nibble values written into an idle register
        for (int wv = 0; wv < 16; wv++) begin
            bit tg, hd, fl;
            int e_ce, e_plt, e_slp, e_rd;
            tg = wv[2]; hd = wv[1]; fl = wv[3];
            ce_per = (wv % 4) + 1;
            e_ce  = (tg && !hd) ? SOFT : 0;
            e_plt = (tg && hd) ? HARD : 0;
            e_slp = (tg && hd && fl) ? FULL : 0;
            e_rd  = (tg && hd) ? 0 : (wv & 8'h0E);
            mark();
            wr(8'hF0 | 8'(wv));
            idle(SETTLE);
            expect_lows($sformatf("R4/R5/R6/R7 value %0h", wv), e_ce, e_plt, e_slp);
            chk(reg_rdata == 8'(e_rd), $sformatf("R2/R10 readback %0h", wv), reg_rdata, e_rd);
            if (tg && !hd) begin
                // R3 rewrite with trigger already set
                mark();
                wr(8'(wv));
                idle(SETTLE);
                expect_lows("R3 repeated trigger", 0, 0, 0);
            end
            wr(8'h00);
            idle(2);
            chk(reg_rdata == 8'h00, "R2 cleared by write", reg_rdata, 0);
        end
        ce_per = 1;

        // R8 R7 external requests, full bit set and clear
        for (int src = 0; src < 3; src++) begin
            for (int f = 0; f < 2; f++) begin
                wr(f ? 8'h08 : 8'h00);
                idle(2);
                mark();
                ext_pulse(src);
                idle(SETTLE);
                expect_lows($sformatf("R8/R7 src %0d full %0d", src, f), 0, 0, f ? FULL : 0);
                chk(reg_rdata == 8'h00, "R10 clear after power cycle", reg_rdata, 0);
            end
        end

        // R9 requests during a hard + full sequence
        mark();
        wr(8'h0E);
        idle(10);
        wr(8'h06);
        chk(reg_rdata == 8'h0E, "R9 register held during hard", reg_rdata, 8'h0E);
        ext_pulse(2);
        idle(HARD);
        wr(8'h0C);
        chk(reg_rdata == 8'h0E, "R9 register held during power", reg_rdata, 8'h0E);
        idle(SETTLE);
        expect_lows("R9 hard not extended", 0, HARD, FULL);
        chk(reg_rdata == 8'h00, "R10 clear after hard", reg_rdata, 0);

        // R9 R10 rewrite during a soft pulse with sparse enables
        ce_per = 3;
        mark();
        wr(8'h04);
        idle(4);
        wr(8'h0E);
        chk(reg_rdata == 8'h04, "R9 register held during soft", reg_rdata, 8'h04);
        idle(SETTLE);
        expect_lows("R9 soft not disturbed", SOFT, 0, 0);
        chk(reg_rdata == 8'h04, "R10 soft keeps register", reg_rdata, 8'h04);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule